// File: doc/BRIEF.md
# USB Line State Monitor

This block watches the full-speed bus pair (D+ and D-) and sorts each sample into one of four line states: J, K, single-ended zero (SE0) or single-ended one (SE1). Both wires first cross into the local clock domain through a synchroniser, and the classified state is then held in a register. Software sees the J and SE0 indications in the top two bits of a control/status byte.

A stability timer counts pulses of a slow tick input, for example a 1 µs tick with a limit of 1000 to give 1 ms. It raises a "line stable" flag once the classified state has stayed the same for the programmed number of ticks. The rising edge of that flag latches a line-change interrupt flag. A separate resume flag latches when the bus enters K, provided resume detection is enabled. Both flags are write-one-to-clear, each in its own status byte. A single interrupt output combines the two flags through their enables.

Top module: `usb_line_mon`

## Requirements
- R1: Bit 7 of `ctrl_stat` is 1 exactly while the classified state is J (D+=1, D-=0). All other bits except bit 6 read 0.
- R2: Bit 6 of `ctrl_stat` is 1 exactly while the classified state is SE0 (D+=0, D-=0). After reset the classified state is SE0.
- R3: While the bus is in K (D+=0, D-=1) or SE1 (both 1), bits 7 and 6 of `ctrl_stat` both read 0.
- R4: Bit 5 of `otg_stat` (stable) is set on the tick that completes `stable_limit` ticks with no change of the classified state. It stays clear before that tick.
- R5: Any change of the classified state clears the stable flag and restarts the tick count from zero. SE1 never becomes stable.
- R6: The cycle after the stable flag rises, bit 5 of `otg_int_stat` is set, whatever the enable.
- R7: A write to `otg_int_stat` or `int_stat` clears bit 5 only where the written data has a 1. A written 0 leaves the flag unchanged. If a set condition and a clear write fall on the same cycle, the set wins.
- R8: The cycle after the classified state enters K from any other state, bit 5 of `int_stat` (resume) is set, but only if bit 5 of `int_en` is 1.
- R9: `irq` is 1 exactly when (bit 5 of `otg_int_stat` and bit 5 of `otg_int_ctl`) or (bit 5 of `int_stat` and bit 5 of `int_en`).
- R10: A change on the D+/D- inputs reaches `ctrl_stat` after exactly three clock edges: two synchroniser stages and the classification register.
- R11: Register writes use `wr_addr` as follows: 0 writes the OTG interrupt control byte, 1 clears OTG status flags (write 1 to clear), 2 writes the interrupt enable byte, 3 clears interrupt status flags (write 1 to clear). The two control bytes read back all eight written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse for the stability timer |
| stable_limit | input | CNT_W | Number of ticks needed for stability |
| dp_in | input | 1 | D+ level, asynchronous |
| dm_in | input | 1 | D- level, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write select |
| wr_data | input | 8 | Register write data |
| ctrl_stat | output | 8 | Bit 7 J, bit 6 SE0 |
| otg_stat | output | 8 | Bit 5 line stable |
| otg_int_ctl | output | 8 | OTG interrupt control byte, bit 5 enables line change |
| otg_int_stat | output | 8 | Bit 5 line-change flag |
| int_en | output | 8 | Interrupt enable byte, bit 5 enables resume |
| int_stat | output | 8 | Bit 5 resume flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The hardest case is restarting the stability count partway through. The count is internal, so the only evidence is when the stable flag rises. The bench lets two of three ticks pass on a held state and then drives a one-cycle glitch to J and back. It then shows that two further ticks leave the flag clear and that a third sets it. A second hard case is the resume gating: the bench enters K once with the enable off and once with it on, from a settled J.

// File: rtl/usb_line_pkg.sv
package usb_line_pkg;
  // encoding is {D-, D+}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    RA_OTG_ICTL  = 2'd0,
    RA_OTG_ISTAT = 2'd1,
    RA_INT_EN    = 2'd2,
    RA_INT_STAT  = 2'd3
  } reg_addr_t;

  localparam int FLAG_BIT = 5;
endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync
  import usb_line_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  dp,
  input  logic  dm,
  output line_t state_q
);
  logic [STAGES-1:0] dp_s, dm_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_s    <= '0;
      dm_s    <= '0;
      state_q <= LS_SE0;
    end else begin
      dp_s    <= {dp_s[STAGES-2:0], dp};
      dm_s    <= {dm_s[STAGES-2:0], dm};
      state_q <= line_t'({dm_s[STAGES-1], dp_s[STAGES-1]});
    end
  end
endmodule

// File: rtl/usb_line_stable.sv
module usb_line_stable
  import usb_line_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  line_t            state,
  output logic             stable
);
  line_t            prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             changed;

  assign changed = (state != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= LS_SE0;
      cnt_q  <= '0;
      stable <= 1'b0;
    end else begin
      prev_q <= state;
      if (changed || state == LS_SE1) begin
        cnt_q  <= '0;
        stable <= 1'b0;
      end else if (tick && !stable) begin
        if ({1'b0, cnt_q} + 1'b1 >= {1'b0, limit}) begin
          stable <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_STABLE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(stable) |-> $past(tick)); // R4
  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state != prev_q) |=> !stable); // R5
  AST_SE1_NEVER_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state == LS_SE1) |=> !stable); // R5
endmodule

// File: rtl/usb_line_regs.sv
module usb_line_regs
  import usb_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  line_t      state,
  input  logic       stable,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] otg_ictl_q,
  output logic [7:0] int_en_q,
  output logic       line_flag_q,
  output logic       rsm_flag_q,
  output logic       irq
);
  logic      stable_d;
  line_t     state_d;
  reg_addr_t addr;
  logic      line_set, rsm_set, line_clr, rsm_clr;

  assign addr     = reg_addr_t'(wr_addr);
  assign line_set = stable && !stable_d;
  assign rsm_set  = int_en_q[FLAG_BIT] && (state == LS_K) && (state_d != LS_K);
  assign line_clr = wr_en && addr == RA_OTG_ISTAT && wr_data[FLAG_BIT];
  assign rsm_clr  = wr_en && addr == RA_INT_STAT && wr_data[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      stable_d    <= 1'b0;
      state_d     <= LS_SE0;
      otg_ictl_q  <= '0;
      int_en_q    <= '0;
      line_flag_q <= 1'b0;
      rsm_flag_q  <= 1'b0;
    end else begin
      stable_d <= stable;
      state_d  <= state;
      if (wr_en && addr == RA_OTG_ICTL) otg_ictl_q <= wr_data;
      if (wr_en && addr == RA_INT_EN)   int_en_q   <= wr_data;
      if (line_set)      line_flag_q <= 1'b1;
      else if (line_clr) line_flag_q <= 1'b0;
      if (rsm_set)       rsm_flag_q  <= 1'b1;
      else if (rsm_clr)  rsm_flag_q  <= 1'b0;
    end
  end

  assign irq = (line_flag_q && otg_ictl_q[FLAG_BIT]) || (rsm_flag_q && int_en_q[FLAG_BIT]);

  AST_LINE_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (stable && !stable_d) |=> line_flag_q); // R6
  AST_RESUME_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(rsm_flag_q) |-> $past(int_en_q[FLAG_BIT])); // R8
  AST_RESUME_ON_K: assert property (@(posedge clk) disable iff (rst)
    $rose(rsm_flag_q) |-> $past(state) == LS_K); // R8
endmodule

// File: rtl/usb_line_mon.sv
module usb_line_mon
  import usb_line_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] stable_limit,
  input  logic             dp_in,
  input  logic             dm_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctrl_stat,
  output logic [7:0]       otg_stat,
  output logic [7:0]       otg_int_ctl,
  output logic [7:0]       otg_int_stat,
  output logic [7:0]       int_en,
  output logic [7:0]       int_stat,
  output logic             irq
);
  line_t state;
  logic  stable, line_flag, rsm_flag;

  usb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .dp(dp_in), .dm(dm_in), .state_q(state)
  );

  usb_line_stable #(.CNT_W(CNT_W)) u_stable (
    .clk(clk), .rst(rst), .tick(tick), .limit(stable_limit),
    .state(state), .stable(stable)
  );

  usb_line_regs u_regs (
    .clk(clk), .rst(rst), .state(state), .stable(stable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .otg_ictl_q(otg_int_ctl), .int_en_q(int_en),
    .line_flag_q(line_flag), .rsm_flag_q(rsm_flag), .irq(irq)
  );

  assign ctrl_stat    = {state == LS_J, state == LS_SE0, 6'b0};
  assign otg_stat     = {2'b0, stable, 5'b0};
  assign otg_int_stat = {2'b0, line_flag, 5'b0};
  assign int_stat     = {2'b0, rsm_flag, 5'b0};

  AST_JSE0_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_stat[7] && ctrl_stat[6])); // R3
endmodule

// File: tb/usb_line_mon_tb.sv
module usb_line_mon_tb_top;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [CNT_W-1:0] stable_limit = 10'd3;
  logic dp_in = 1'b0, dm_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] ctrl_stat, otg_stat, otg_int_ctl, otg_int_stat, int_en, int_stat;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_line_mon #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .stable_limit(stable_limit),
    .dp_in(dp_in), .dm_in(dm_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_stat(ctrl_stat), .otg_stat(otg_stat),
    .otg_int_ctl(otg_int_ctl), .otg_int_stat(otg_int_stat),
    .int_en(int_en), .int_stat(int_stat), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line(logic dp, logic dm);
    @(negedge clk); dp_in = dp; dm_in = dm;
  endtask

  task automatic settle(logic dp, logic dm);
    line(dp, dm); cyc(5);
  endtask

  task automatic pulse_tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset ctrl", ctrl_stat, 8'h40);
    chk("R4 reset stable", otg_stat, 8'h00);
    chk("R6 reset otg flag", otg_int_stat, 8'h00);
    chk("R8 reset resume", int_stat, 8'h00);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_classify();
    settle(1, 0); chk("R1 J", ctrl_stat, 8'h80);
    settle(0, 1); chk("R3 K", ctrl_stat, 8'h00);
    settle(0, 0); chk("R2 SE0", ctrl_stat, 8'h40);
    settle(1, 1); chk("R3 SE1", ctrl_stat, 8'h00);
    pulse_tick(6); chk("R5 SE1 never stable", otg_stat, 8'h00);
  endtask

  task automatic t_latency();
    settle(0, 0);
    line(1, 0);         // inputs change after this negedge
    cyc(2); chk("R10 after two edges", ctrl_stat, 8'h40);
    cyc(1); chk("R10 after three edges", ctrl_stat, 8'h80);
  endtask

  task automatic t_stable();
    settle(0, 0);
    pulse_tick(2); chk("R4 two ticks", otg_stat, 8'h00);
    pulse_tick(1); chk("R4 third tick", otg_stat, 8'h20);
    // restart partway
    settle(1, 0); settle(0, 0);
    pulse_tick(2);
    line(1, 0); line(0, 0); cyc(5);
    pulse_tick(2); chk("R5 restarted count", otg_stat, 8'h00);
    pulse_tick(1); chk("R5 after full count", otg_stat, 8'h20);
    line(0, 1); cyc(4); chk("R5 K clears stable", otg_stat, 8'h00);
  endtask

  task automatic t_line_irq();
    settle(1, 0);
    wr(2'd1, 8'hFF);
    chk("R7 line flag cleared", otg_int_stat, 8'h00);
    wr(2'd0, 8'h20);
    chk("R11 otg ctl readback", otg_int_ctl, 8'h20);
    pulse_tick(3); cyc(1);
    chk("R6 line flag set", otg_int_stat, 8'h20);
    chk("R9 irq line", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'hDF);
    chk("R7 zero write keeps flag", otg_int_stat, 8'h20);
    wr(2'd1, 8'h20);
    chk("R7 w1c clears flag", otg_int_stat, 8'h00);
    chk("R9 irq off", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h5A);
    chk("R11 otg ctl all bits", otg_int_ctl, 8'h5A);
    settle(0, 0); pulse_tick(3); cyc(1);
    chk("R6 flag without enable", otg_int_stat, 8'h20);
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h20);
  endtask

  task automatic t_resume();
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    settle(1, 0);
    settle(0, 1);
    chk("R8 disabled no resume", int_stat, 8'h00);
    wr(2'd2, 8'h20);
    chk("R11 int_en readback", int_en, 8'h20);
    settle(1, 0);
    chk("R8 J not resume", int_stat, 8'h00);
    settle(0, 1);
    chk("R8 resume set", int_stat, 8'h20);
    chk("R9 irq resume", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h20);
    chk("R7 resume cleared", int_stat, 8'h00);
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);
    settle(0, 1);
    chk("R8 held K no new resume", int_stat, 8'h00);
  endtask

  initial begin
    cyc(3);
    @(negedge clk); rst = 1'b0;
    cyc(1);
    t_reset();
    t_classify();
    t_latency();
    t_stable();
    t_line_irq();
    t_resume();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule